// File: doc/BRIEF.md
# Age-Ordered Multi-Version Speculation Store

This block holds speculative data for a small group of threads that run in a fixed age order, from oldest to youngest. Each thread may keep its own version of any address, so several versions of the same location can exist side by side. A load sees the newest version visible to the requesting thread. That version is the one written by the youngest thread that is not younger than the requester. When no such version exists, the load returns the committed memory value. A thread never sees a value written by a younger thread.

Each thread leaves a read mark on every address it loads without hitting its own version. If an older thread later writes that address, the youngest readers have consumed stale data. The block then aborts the oldest offending reader together with every thread younger than it, and drops all of their versions and read marks. Only the oldest thread can retire. Retiring copies its versions into committed memory, frees its entries and passes the oldest role to the next thread in a ring. After that, the retired thread slot becomes the youngest.

Top module: `spec_vbuf`

## Requirements
- R1: After reset the abort vector is all zero, the oldest thread id is 0, stall is low, and every load returns 0 from committed memory.
- R2: A load by thread T returns in the same cycle the data of the version written by the youngest thread whose age is at or below T's age. If there is none, it returns the committed value. Age is (thread id − oldest id) mod NTHR.
- R3: A load never returns a version written by a thread younger than the requester.
- R4: A repeated write by a thread to an address it already holds updates that version in place and uses no further entry.
- R5: A write by thread W to address A raises abort_o, for exactly the cycle after the write edge, on the oldest thread younger than W that holds a read mark on A, and on every thread younger than that one. W and older threads are never aborted.
- R6: A load served by the requester's own version leaves no read mark, so a later older write to that address aborts nobody.
- R7: An aborted thread loses all its versions and read marks; its later loads see only older versions or committed data.
- R8: With ret_i high, the oldest thread's versions reach committed memory, its entries are freed, and oldest_o advances by one modulo NTHR at the same edge.
- R9: A write that needs a new entry when all NENT entries are in use is stalled with no effect if the requester is the oldest thread. Otherwise the write is dropped, and the requester and all younger threads are aborted.
- R10: A request presented in a cycle with ret_i high is stalled and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | A request is presented this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_tid | input | TW | Requesting thread id |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| rdata | output | DW | Load result, valid in the request cycle |
| stall_o | output | 1 | Request not accepted this cycle |
| ret_i | input | 1 | Retire the oldest thread |
| abort_o | output | NTHR | One-cycle abort pulse per thread id |
| oldest_o | output | TW | Id of the current oldest thread |

## Verification
Load data and stall are combinational results of the request. The bench drives each request after a falling edge and samples rdata and stall_o one time step later, before the rising edge that commits the request. Aborts are registered, so abort_o is read at the falling edge after the rising edge of the offending store, and only for that one cycle. oldest_o and committed data change at the retire edge, so they are checked through ports and through loads issued in the following cycle.

// File: rtl/spec_vbuf.sv
module spec_vbuf #(
  parameter int NTHR = 4,
  parameter int AW   = 4,
  parameter int DW   = 8,
  parameter int NENT = 8,
  localparam int TW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_vld,
  input  logic            req_we,
  input  logic [TW-1:0]   req_tid,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic [DW-1:0]   rdata,
  output logic            stall_o,
  input  logic            ret_i,
  output logic [NTHR-1:0] abort_o,
  output logic [TW-1:0]   oldest_o
);
  localparam int DEPTH = 1 << AW;
  localparam int EW    = (NENT > 1) ? $clog2(NENT) : 1;

  logic [DW-1:0]    mem  [DEPTH];
  logic [NENT-1:0]  ev;
  logic [TW-1:0]    eown [NENT];
  logic [AW-1:0]    eadr [NENT];
  logic [DW-1:0]    edat [NENT];
  logic [DEPTH-1:0] rmark [NTHR];
  logic [TW-1:0]    head;
  logic [NTHR-1:0]  abort_q, kill;

  logic          hit_own, have_free, go, wr, full_fail, is_oldest;
  logic [EW-1:0] own_idx, free_idx;
  int            req_age, best_age, viol, kill_age;

  function automatic int age_of(input logic [TW-1:0] t, input logic [TW-1:0] h);
    return (int'(t) >= int'(h)) ? int'(t) - int'(h) : int'(t) + NTHR - int'(h);
  endfunction

  assign abort_o   = abort_q;
  assign oldest_o  = head;
  assign is_oldest = (req_tid == head);
  assign go        = req_vld && !ret_i;
  assign wr        = go && req_we;
  assign full_fail = wr && !hit_own && !have_free;
  assign stall_o   = req_vld && (ret_i || (full_fail && is_oldest));

  always_comb begin
    req_age  = age_of(req_tid, head);
    best_age = -1;
    rdata    = mem[req_addr];
    hit_own  = 1'b0;
    own_idx  = '0;
    for (int e = 0; e < NENT; e++) begin
      if (ev[e] && eadr[e] == req_addr) begin
        if (age_of(eown[e], head) <= req_age && age_of(eown[e], head) > best_age) begin
          best_age = age_of(eown[e], head);
          rdata    = edat[e];
        end
        if (eown[e] == req_tid) begin
          hit_own = 1'b1;
          own_idx = EW'(e);
        end
      end
    end
    have_free = 1'b0;
    free_idx  = '0;
    for (int e = NENT - 1; e >= 0; e--) begin
      if (!ev[e]) begin
        have_free = 1'b1;
        free_idx  = EW'(e);
      end
    end
    viol = NTHR;
    for (int t = 0; t < NTHR; t++) begin
      if (rmark[t][req_addr] && age_of(TW'(t), head) > req_age && age_of(TW'(t), head) < viol)
        viol = age_of(TW'(t), head);
    end
    kill_age = NTHR;
    if (full_fail && !is_oldest)   kill_age = req_age;
    else if (wr && !full_fail)     kill_age = viol;
    for (int t = 0; t < NTHR; t++)
      kill[t] = age_of(TW'(t), head) >= kill_age;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head    <= '0;
      abort_q <= '0;
      ev      <= '0;
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
      for (int t = 0; t < NTHR; t++) rmark[t] <= '0;
      for (int e = 0; e < NENT; e++) begin
        eown[e] <= '0;
        eadr[e] <= '0;
        edat[e] <= '0;
      end
    end else begin
      abort_q <= kill;
      if (ret_i) begin
        for (int e = 0; e < NENT; e++) begin
          if (ev[e] && eown[e] == head) begin
            mem[eadr[e]] <= edat[e];
            ev[e]        <= 1'b0;
          end
        end
        rmark[head] <= '0;
        head        <= (int'(head) == NTHR - 1) ? '0 : head + 1'b1;
      end else begin
        for (int e = 0; e < NENT; e++)
          if (ev[e] && kill[eown[e]]) ev[e] <= 1'b0;
        for (int t = 0; t < NTHR; t++)
          if (kill[t]) rmark[t] <= '0;
        if (go && !req_we && !hit_own)
          rmark[req_tid][req_addr] <= 1'b1;
        if (wr && !kill[req_tid]) begin
          if (hit_own) begin
            edat[own_idx] <= req_wdata;
          end else if (have_free) begin
            ev[free_idx]   <= 1'b1;
            eown[free_idx] <= req_tid;
            eadr[free_idx] <= req_addr;
            edat[free_idx] <= req_wdata;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spec_vbuf_chk.sv
module spec_vbuf_chk #(
  parameter int NTHR = 4,
  parameter int TW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_vld,
  input logic            ret_i,
  input logic            stall_o,
  input logic [NTHR-1:0] abort_o,
  input logic [TW-1:0]   oldest_o
);
  a_r5_oldest_safe: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o[oldest_o] == 1'b0);

  for (genvar a = 1; a < NTHR; a++) begin : g_sfx
    a_r5_abort_suffix: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o[(int'(oldest_o) + a - 1) % NTHR] |-> abort_o[(int'(oldest_o) + a) % NTHR]);
  end

  a_r8_head_step: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i |=> int'(oldest_o) == (int'($past(oldest_o)) + 1) % NTHR);

  a_r8_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_i |=> $stable(oldest_o));

  a_r10_retire_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && req_vld) |-> stall_o);

  a_r9_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> abort_o == '0);
endmodule

bind spec_vbuf spec_vbuf_chk #(.NTHR(NTHR), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .ret_i(ret_i),
  .stall_o(stall_o), .abort_o(abort_o), .oldest_o(oldest_o));

// File: tb/tb_spec_vbuf.sv
module tb_spec_vbuf;
  localparam int NTHR = 4, AW = 4, DW = 8, NENT = 8, TW = 2;

  logic clk = 0, rst_n = 0;
  logic req_vld = 0, req_we = 0, ret_i = 0;
  logic [TW-1:0] req_tid = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rdata;
  logic stall_o;
  logic [NTHR-1:0] abort_o;
  logic [TW-1:0] oldest_o;

  int checks = 0, fails = 0, cyc = 0;
  logic [DW-1:0] s_rdata;
  logic s_stall;

  spec_vbuf #(.NTHR(NTHR), .AW(AW), .DW(DW), .NENT(NENT)) dut (.*);

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic we, input int tid, input int addr, input int data, input logic ret = 0);
    @(negedge clk);
    req_vld = 1; req_we = we; req_tid = TW'(tid); req_addr = AW'(addr);
    req_wdata = DW'(data); ret_i = ret;
    #1 s_rdata = rdata; s_stall = stall_o;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    req_vld = 0; req_we = 0; ret_i = 0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req_vld = 0; ret_i = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    int exp_v;
    int nstall;
    do_reset();
    // R1
    chk("R1 abort", abort_o, 0);
    chk("R1 oldest", oldest_o, 0);
    op(0, 3, 4, 0);
    chk("R1 load", s_rdata, 0);
    chk("R1 stall", s_stall, 0);

    // R5 / R7
    op(1, 3, 9, 8'hA9);
    op(0, 2, 5, 0);
    chk("R2 load committed", s_rdata, 0);
    op(1, 0, 5, 8'h55);
    idle();
    chk("R5 abort mask", abort_o, 4'b1100);
    op(0, 3, 9, 0);
    chk("R7 version dropped", s_rdata, 0);
    op(0, 1, 5, 0);
    chk("R2 older version", s_rdata, 8'h55);

    // R6
    do_reset();
    op(1, 2, 7, 8'h27);
    op(0, 2, 7, 0);
    chk("R6 own read", s_rdata, 8'h27);
    op(1, 1, 7, 8'h17);
    idle();
    chk("R6 no abort", abort_o, 0);
    op(0, 2, 7, 0);
    chk("R6 own kept", s_rdata, 8'h27);
    op(0, 3, 7, 0);
    chk("R2 nearest older", s_rdata, 8'h27);

    // R4 / R9
    do_reset();
    nstall = 0;
    for (int v = 1; v <= 9; v++) begin op(1, 0, 0, v); nstall += s_stall; end
    for (int a = 1; a <= 7; a++) begin op(1, 0, a, 8'h40 + a); nstall += s_stall; end
    chk("R4 no stall on rewrite", nstall, 0);
    op(0, 0, 0, 0);
    chk("R4 last value", s_rdata, 9);
    op(1, 0, 8, 8'h88);
    chk("R9 oldest stall", s_stall, 1);
    idle();
    chk("R9 stall no abort", abort_o, 0);
    op(0, 0, 8, 0);
    chk("R9 stalled write dropped", s_rdata, 0);
    op(1, 2, 9, 8'h99);
    chk("R9 young no stall", s_stall, 0);
    idle();
    chk("R9 young abort", abort_o, 4'b1100);
    op(0, 2, 9, 0);
    chk("R9 dropped write", s_rdata, 0);

    // R8 / R10
    op(1, 1, 11, 8'h77, 1);
    chk("R10 stall on retire", s_stall, 1);
    idle();
    chk("R8 oldest advance", oldest_o, 1);
    op(0, 1, 11, 0);
    chk("R10 no effect", s_rdata, 0);
    op(0, 1, 0, 0);
    chk("R8 committed", s_rdata, 9);
    op(0, 0, 3, 0);
    chk("R8 committed other", s_rdata, 8'h43);
    op(1, 1, 12, 8'h12);
    chk("R8 entries freed", s_stall, 0);

    // R5 sweep: reader r loads, writer w stores
    for (int w = 0; w < NTHR; w++)
      for (int r = 0; r < NTHR; r++) begin
        if (r == w) continue;
        do_reset();
        op(0, r, 5, 0);
        op(1, w, 5, 8'h5A);
        idle();
        exp_v = (r > w) ? (((1 << NTHR) - 1) & ~((1 << r) - 1)) : 0;
        chk($sformatf("R5 sweep w%0d r%0d", w, r), abort_o, exp_v);
      end

    // R2 R3 sweep: writer subsets, every reader
    for (int m = 0; m < (1 << NTHR); m++) begin
      do_reset();
      for (int t = 0; t < NTHR; t++)
        if (m[t]) op(1, t, 3, 8'h10 * t + m + 1);
      for (int r = 0; r < NTHR; r++) begin
        exp_v = 0;
        for (int t = 0; t <= r; t++) if (m[t]) exp_v = 8'h10 * t + m + 1;
        op(0, r, 3, 0);
        chk($sformatf("R2 R3 sweep m%0d r%0d", m, r), s_rdata, exp_v);
      end
    end

    idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule